// File: doc/BRIEF.md
# Line-Cycle Fault Qualification Bank

This block turns six raw, active-low fault status lines into latched, debounced fault flags. Each line has its own persistence rule. Some channels need a run of consecutive low samples. One is sampled only on every fourth line cycle. One votes over fixed blocks of readings. Sampling is paced by a one-cycle line-cycle tick, or by a quarter-cycle strobe for the bus overvoltage channel. Two channels are evaluated only while a mode qualifier is true.

A priority encoder looks at the latched flags and reports a one-byte display code for the most important active fault. It also reports whether that fault can be cleared. The clear input removes only the recoverable faults and restarts their qualification. The other faults stay latched until reset.

Top module: `fault_qual_bank`

## Requirements
- R1: After reset, `fault_o`, `disp_code` and `recov_o` are all zero. Bit positions in `fault_o` are: 0 logic supply, 1 relay weld, 2 backfeed weld, 3 bus overvoltage, 4 overtemperature, 5 fan.
- R2: Relay weld sets `fault_o[1]` on the line tick that brings its run of consecutive low `weld_n` readings, taken while `batt_mode` is 1, to 25. A tick with `weld_n` high or `batt_mode` low resets the run to zero.
- R3: Backfeed weld sets `fault_o[2]` after 25 consecutive line ticks with `bfweld_n` low while `bf_open` is 1. Any other tick resets its run.
- R4: Bus overvoltage is sampled on `qtr_stb`. It sets `fault_o[3]` on the second consecutive low `busov_n` sample. A high sample resets the run.
- R5: The fan line is read on the 1st, 5th, 9th, ... line tick after reset (every fourth tick). It sets `fault_o[5]` after 32 consecutive low readings. Ticks in between are ignored, and a high reading resets the run.
- R6: Overtemperature sets `fault_o[4]` after `otemp_n` is low on 2 consecutive line ticks.
- R7: The logic supply line is read on every line tick, in non-overlapping blocks of 10 readings counted from reset. `fault_o[0]` is set at the end of a block in which 7 or more readings were low.
- R8: A flag rises at the clock edge that takes the qualifying sample, and then stays set. `clear_rec` drops flags 3, 4 and 5 and restarts their runs (clear wins over a same-cycle sample). It has no effect on flags 0, 1 and 2, which only reset removes. Runs saturate and never wrap.
- R9: `disp_code` reports the highest-priority set flag, in this order: logic supply 0x01, relay weld 0x0D, backfeed weld 0x0C, bus overvoltage 0x08, overtemperature 0x07, fan 0x10. It is 0x00 when no flag is set.
- R10: `recov_o` is 1 exactly when the fault that `disp_code` reports is one of the recoverable faults (bus overvoltage, overtemperature, fan).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_tick | input | 1 | One-cycle pulse per AC line cycle |
| qtr_stb | input | 1 | One-cycle pulse per quarter-cycle sample point |
| clear_rec | input | 1 | Clears the recoverable faults |
| batt_mode | input | 1 | Unit is running from battery (relay-weld qualifier) |
| bf_open | input | 1 | Backfeed relays commanded open (backfeed-weld qualifier) |
| weld_n | input | 1 | Relay weld sense, active low |
| bfweld_n | input | 1 | Backfeed weld sense, active low |
| busov_n | input | 1 | Bus overvoltage status, active low |
| fan_n | input | 1 | Fan status, active low |
| lps_n | input | 1 | Logic supply status, active low |
| otemp_n | input | 1 | Overtemperature status, active low |
| fault_o | output | 6 | Latched fault flags |
| disp_code | output | 8 | Display code of the top-priority fault |
| recov_o | output | 1 | Reported fault is recoverable |

## Verification
The bench targets runs that break one sample short of the limit, so a counter off by one would latch early or miss the fault. It drops the mode qualifiers in the middle of a weld run; a channel that did not restart would latch on a split run. It relies on the fan decimation phase fixed from reset, and on the vote blocks aligned to reset, so an error in the phase or in the block boundaries shows up as a flag at the wrong cycle. It asserts clear together with faults of every kind: a design that clears too much would drop a weld or supply flag, and one that kept the run count would re-latch the fault early. Priority is checked by building up many flag mixes.

// File: rtl/fq_pkg.sv
package fq_pkg;
    localparam int NCH       = 6;
    localparam int CH_LPS    = 0;
    localparam int CH_WELD   = 1;
    localparam int CH_BFW    = 2;
    localparam int CH_BUSOV  = 3;
    localparam int CH_OTEMP  = 4;
    localparam int CH_FAN    = 5;
    localparam int CODE_W    = 8;
    localparam int VOTE_N    = 10;
    localparam int VOTE_K    = 7;

    // channels that the clear input may drop
    localparam logic [NCH-1:0] RECOV_MASK = 6'b111000;

    function automatic logic [CODE_W-1:0] code_of(input int ch);
        case (ch)
            CH_LPS:   return 8'h01;
            CH_WELD:  return 8'h0D;
            CH_BFW:   return 8'h0C;
            CH_BUSOV: return 8'h08;
            CH_OTEMP: return 8'h07;
            CH_FAN:   return 8'h10;
            default:  return 8'h00;
        endcase
    endfunction

    function automatic int run_limit(input int ch);
        case (ch)
            CH_WELD, CH_BFW:    return 25;
            CH_BUSOV, CH_OTEMP: return 2;
            CH_FAN:             return 32;
            default:            return 1;
        endcase
    endfunction

    function automatic int run_decim(input int ch);
        return (ch == CH_FAN) ? 4 : 1;
    endfunction
endpackage

// File: rtl/fq_run_qual.sv
module fq_run_qual #(
    parameter int LIMIT = 25,
    parameter int DECIM = 1,
    parameter bit RECOV = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic enable,
    input  logic raw_n,
    input  logic clear,
    output logic flag
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam int PW = (DECIM > 1) ? $clog2(DECIM) : 1;
    localparam logic [CW-1:0] LIM_C   = CW'(LIMIT);
    localparam logic [PW-1:0] PH_LAST = PW'(DECIM - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [PW-1:0] phase;
        logic          flag;
    } run_st_t;

    run_st_t st_d, st_q;

    always_comb begin
        logic take;
        st_d = st_q;
        take = strobe && (st_q.phase == '0);
        if (strobe) begin
            st_d.phase = (st_q.phase == PH_LAST) ? '0 : st_q.phase + 1'b1;
        end
        if (take) begin
            if (enable && !raw_n) begin
                if (st_q.cnt != LIM_C) st_d.cnt = st_q.cnt + 1'b1;
                if (st_d.cnt == LIM_C) st_d.flag = 1'b1;
            end else begin
                st_d.cnt = '0;
            end
        end
        if (RECOV && clear) begin
            st_d.cnt  = '0;
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;
endmodule

// File: rtl/fq_vote_qual.sv
module fq_vote_qual #(
    parameter int N = 10,
    parameter int K = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic raw_n,
    output logic flag
);
    localparam int RW = $clog2(N + 1);
    localparam logic [RW-1:0] LAST_C = RW'(N - 1);
    localparam logic [RW-1:0] K_C    = RW'(K);

    typedef struct packed {
        logic [RW-1:0] reads;
        logic [RW-1:0] lows;
        logic          flag;
    } vote_st_t;

    vote_st_t st_d, st_q;

    always_comb begin
        logic [RW-1:0] lows_n;
        st_d   = st_q;
        lows_n = st_q.lows + RW'(!raw_n);
        if (strobe) begin
            if (st_q.reads == LAST_C) begin
                if (lows_n >= K_C) st_d.flag = 1'b1;
                st_d.reads = '0;
                st_d.lows  = '0;
            end else begin
                st_d.reads = st_q.reads + 1'b1;
                st_d.lows  = lows_n;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;
endmodule

// File: rtl/fq_prio.sv
module fq_prio
    import fq_pkg::*;
(
    input  logic [NCH-1:0]    flags,
    output logic [CODE_W-1:0] code,
    output logic              recov
);
    // lowest index wins: scan from the bottom of the order upwards
    always_comb begin
        code  = '0;
        recov = 1'b0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (flags[i]) begin
                code  = code_of(i);
                recov = RECOV_MASK[i];
            end
        end
    end
endmodule

// File: rtl/fault_qual_bank.sv
module fault_qual_bank
    import fq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_tick,
    input  logic              qtr_stb,
    input  logic              clear_rec,
    input  logic              batt_mode,
    input  logic              bf_open,
    input  logic              weld_n,
    input  logic              bfweld_n,
    input  logic              busov_n,
    input  logic              fan_n,
    input  logic              lps_n,
    input  logic              otemp_n,
    output logic [NCH-1:0]    fault_o,
    output logic [CODE_W-1:0] disp_code,
    output logic              recov_o
);
    logic [NCH-1:0] raw_vec;
    logic [NCH-1:0] en_vec;
    logic [NCH-1:0] stb_vec;
    logic [NCH-1:0] flag_vec;

    always_comb begin
        raw_vec           = '1;
        raw_vec[CH_LPS]   = lps_n;
        raw_vec[CH_WELD]  = weld_n;
        raw_vec[CH_BFW]   = bfweld_n;
        raw_vec[CH_BUSOV] = busov_n;
        raw_vec[CH_OTEMP] = otemp_n;
        raw_vec[CH_FAN]   = fan_n;

        en_vec           = '1;
        en_vec[CH_WELD]  = batt_mode;
        en_vec[CH_BFW]   = bf_open;

        stb_vec            = {NCH{line_tick}};
        stb_vec[CH_BUSOV]  = qtr_stb;
    end

    fq_vote_qual #(.N(VOTE_N), .K(VOTE_K)) u_lps (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (stb_vec[CH_LPS]),
        .raw_n  (raw_vec[CH_LPS]),
        .flag   (flag_vec[CH_LPS])
    );

    for (genvar g = CH_LPS + 1; g < NCH; g++) begin : g_run
        fq_run_qual #(
            .LIMIT (run_limit(g)),
            .DECIM (run_decim(g)),
            .RECOV (RECOV_MASK[g])
        ) u_run (
            .clk    (clk),
            .rst_n  (rst_n),
            .strobe (stb_vec[g]),
            .enable (en_vec[g]),
            .raw_n  (raw_vec[g]),
            .clear  (clear_rec),
            .flag   (flag_vec[g])
        );
    end

    fq_prio u_prio (
        .flags (flag_vec),
        .code  (disp_code),
        .recov (recov_o)
    );

    assign fault_o = flag_vec;
endmodule

// File: rtl/fq_checker.sv
module fq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       line_tick,
    input logic       qtr_stb,
    input logic       clear_rec,
    input logic       busov_n,
    input logic       otemp_n,
    input logic [5:0] fault_o,
    input logic [7:0] disp_code,
    input logic       recov_o
);
    // R8
    nonrec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o[0] && fault_o[1] |=> fault_o[0] && fault_o[1]);

    // R8
    bfw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o[2] |=> fault_o[2]);

    // R8
    rec_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_o[3]) || $fell(fault_o[4]) || $fell(fault_o[5]) |-> $past(clear_rec));

    // R4
    busov_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_o[3]) |-> $past(qtr_stb) && !$past(busov_n));

    // R6
    otemp_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_o[4]) |-> $past(line_tick) && !$past(otemp_n));

    // R9
    code_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o == 6'b0) == (disp_code == 8'h00));

    // R10
    recov_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        recov_o |-> (fault_o[2:0] == 3'b0) && (fault_o[5:3] != 3'b0));
endmodule

bind fault_qual_bank fq_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_tick (line_tick),
    .qtr_stb   (qtr_stb),
    .clear_rec (clear_rec),
    .busov_n   (busov_n),
    .otemp_n   (otemp_n),
    .fault_o   (fault_o),
    .disp_code (disp_code),
    .recov_o   (recov_o)
);

// File: tb/sim_fault_qual_bank.sv
`timescale 1ns/1ps
module sim_fault_qual_bank;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_tick = 0, qtr_stb = 0, clear_rec = 0, batt_mode = 0, bf_open = 0;
    logic weld_n = 1, bfweld_n = 1, busov_n = 1, fan_n = 1, lps_n = 1, otemp_n = 1;
    logic [5:0] fault_o;
    logic [7:0] disp_code;
    logic       recov_o;

    always #2.5 clk = ~clk;

    fault_qual_bank u0 (
        .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .qtr_stb(qtr_stb),
        .clear_rec(clear_rec), .batt_mode(batt_mode), .bf_open(bf_open),
        .weld_n(weld_n), .bfweld_n(bfweld_n), .busov_n(busov_n), .fan_n(fan_n),
        .lps_n(lps_n), .otemp_n(otemp_n), .fault_o(fault_o),
        .disp_code(disp_code), .recov_o(recov_o)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    int m_cnt[6];
    int m_phase, m_reads, m_lows;
    logic [5:0] m_flags;

    function automatic int lim(input int ch);
        case (ch)
            1, 2: return 25;
            3, 4: return 2;
            5:    return 32;
            default: return 1;
        endcase
    endfunction

    function automatic logic [7:0] exp_code(input logic [5:0] f);
        if (f[0]) return 8'h01;
        if (f[1]) return 8'h0D;
        if (f[2]) return 8'h0C;
        if (f[3]) return 8'h08;
        if (f[4]) return 8'h07;
        if (f[5]) return 8'h10;
        return 8'h00;
    endfunction

    function automatic logic exp_rec(input logic [5:0] f);
        return (f[2:0] == 3'b0) && (f[5:3] != 3'b0);
    endfunction

    function automatic string tag_of(input int ch);
        case (ch)
            0: return "R7";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R6";
            default: return "R5";
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 6; i++) m_cnt[i] = 0;
        m_phase = 0; m_reads = 0; m_lows = 0; m_flags = '0;
    endtask

    task automatic model_step(input bit t, q, c, bm, bo, input logic [5:0] raw);
        int lows_n;
        bit take, en, stb;
        if (t) begin
            lows_n = m_lows + (raw[0] ? 0 : 1);
            if (m_reads == 9) begin
                if (lows_n >= 7) m_flags[0] = 1'b1;
                m_reads = 0; m_lows = 0;
            end else begin
                m_reads++; m_lows = lows_n;
            end
        end
        for (int i = 1; i < 6; i++) begin
            stb  = (i == 3) ? q : t;
            en   = (i == 1) ? bm : (i == 2) ? bo : 1'b1;
            take = stb && (i != 5 || m_phase == 0);
            if (take) begin
                if (en && !raw[i]) begin
                    if (m_cnt[i] < lim(i)) m_cnt[i]++;
                    if (m_cnt[i] == lim(i)) m_flags[i] = 1'b1;
                end else m_cnt[i] = 0;
            end
            if (c && i >= 3) begin
                m_cnt[i] = 0; m_flags[i] = 1'b0;
            end
        end
        if (t) m_phase = (m_phase + 1) % 4;
    endtask

    task automatic compare();
        for (int i = 0; i < 6; i++) begin
            checks++;
            if (fault_o[i] !== m_flags[i]) begin
                fails++;
                $display("FAIL %s flag %0d: got %b expected %b at %0t", tag_of(i), i, fault_o[i], m_flags[i], $time);
            end
        end
        checks++;
        if (disp_code !== exp_code(m_flags)) begin
            fails++;
            $display("FAIL R9 code: got %h expected %h at %0t", disp_code, exp_code(m_flags), $time);
        end
        checks++;
        if (recov_o !== exp_rec(m_flags)) begin
            fails++;
            $display("FAIL R10 recov: got %b expected %b at %0t", recov_o, exp_rec(m_flags), $time);
        end
    endtask

    // one cycle: check outputs, drive new inputs, advance the model, wait
    task automatic step(input bit r, t, q, c, bm, bo, input logic [5:0] raw);
        compare();
        rst_n = r; line_tick = t; qtr_stb = q; clear_rec = c;
        batt_mode = bm; bf_open = bo;
        lps_n = raw[0]; weld_n = raw[1]; bfweld_n = raw[2];
        busov_n = raw[3]; otemp_n = raw[4]; fan_n = raw[5];
        if (!r) model_reset();
        else    model_step(t, q, c, bm, bo, raw);
        @(negedge clk);
    endtask

    function automatic logic [5:0] rand_raw(input int pct_low);
        logic [5:0] v;
        for (int i = 0; i < 6; i++) v[i] = ($urandom % 100) >= pct_low;
        return v;
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        @(negedge clk);
        // R1: reset state
        step(0, 0, 0, 0, 0, 0, 6'h3F);
        step(0, 0, 0, 0, 0, 0, 6'h3F);
        checks++;
        if (fault_o !== 6'b0 || disp_code !== 8'h00 || recov_o !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: got %b/%h/%b expected 0/00/0", fault_o, disp_code, recov_o);
        end
        // R2: weld run broken at 24 by dropping battery mode, then a full 25-run
        for (int k = 0; k < 24; k++) step(1, 1, 0, 0, 1, 0, 6'b111101);
        step(1, 1, 0, 0, 0, 0, 6'b111101);
        for (int k = 0; k < 24; k++) step(1, 1, 0, 0, 1, 0, 6'b111101);
        checks++;
        if (fault_o[1] !== 1'b0) begin
            fails++; $display("FAIL R2 early latch: got %b expected 0", fault_o[1]);
        end
        step(1, 1, 0, 0, 1, 0, 6'b111101);
        step(1, 0, 0, 0, 1, 0, 6'b111111);
        checks++;
        if (fault_o[1] !== 1'b1 || disp_code !== 8'h0D) begin
            fails++; $display("FAIL R2 latch: got %b/%h expected 1/0D", fault_o[1], disp_code);
        end
        // R8: clear has no effect on weld
        step(1, 0, 0, 1, 0, 0, 6'h3F);
        step(1, 0, 0, 0, 0, 0, 6'h3F);
        checks++;
        if (fault_o[1] !== 1'b1) begin
            fails++; $display("FAIL R8 weld cleared: got %b expected 1", fault_o[1]);
        end
        // reset, then all lines low with ticks and strobes every cycle
        step(0, 0, 0, 0, 0, 0, 6'h3F);
        for (int k = 0; k < 200; k++) step(1, 1, 1, 0, 1, 1, 6'h00);
        // R8: clear together with a qualifying sample; recoverable restart
        step(1, 1, 1, 1, 1, 1, 6'h00);
        step(1, 1, 1, 0, 1, 1, 6'h00);
        checks++;
        if (fault_o !== 6'b000111) begin
            fails++; $display("FAIL R8 clear: got %b expected 000111", fault_o);
        end
        for (int k = 0; k < 200; k++) step(1, (k % 3) == 0, k[0], 0, 1, 1, 6'h3F);
        // randomized segments
        for (int seg = 0; seg < 16; seg++) begin
            int pl = 40 + (seg * 4);
            int tp = 20 + (seg % 4) * 25;
            step(0, 0, 0, 0, 0, 0, 6'h3F);
            for (int k = 0; k < 1500; k++) begin
                bit t  = ($urandom % 100) < tp;
                bit q  = ($urandom % 100) < 50;
                bit c  = ($urandom % 400) == 0;
                bit bm = ($urandom % 50) != 0;
                bit bo = ($urandom % 60) != 0;
                step(1, t, q, c, bm, bo, rand_raw(pl));
            end
        end
        step(1, 0, 0, 0, 0, 0, 6'h3F);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(150000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired: got hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule